// File: doc/BRIEF.md
# Masked SIMD Accumulator Array

This block is the datapath of a lane-parallel array processor. It holds one signed accumulator per lane, and each lane owns one bank of an interleaved data memory. A control sequencer issues one opcode per cycle. Every lane executes that opcode in the same cycle: it loads, stores, adds or multiplies against the word at a shared row address of its own bank, copies one chosen lane's accumulator, or compares its accumulator with its memory word.

A per-lane enable mask selects which lanes commit. A disabled lane keeps its accumulator and issues no memory write. The compare results are packed into a word that goes to a small file of index registers. From there the sequencer can load that word into the mask, invert the mask, or reset the mask to all lanes. An if/else is therefore run as a sequence: compare, load the mask, run the then-arm, invert the mask, run the else-arm, enable all lanes. The index registers also supply a row address or a broadcast lane in place of the immediate fields.

The memory banks are outside the block. The block drives the effective row and the per-lane write enables and write data. It receives the per-lane read words of that row in the same cycle.

Top module: `simd_array`

## Requirements
- R1: After synchronous reset every accumulator is zero, `lane_mask` is all ones, `cmp_flags` is zero and every index register is zero.
- R2: With `in_valid` high, opcode 1 loads each enabled lane's accumulator with its bank word at the effective row. Opcode 3 adds that word to the accumulator and opcode 4 multiplies the accumulator by it, keeping the low 16 bits. Each result is visible from the next cycle.
- R3: With `in_valid` high, opcode 2 raises `mem_wr_en[k]` in the same cycle for every enabled lane k, with that lane's accumulator on `mem_wr_data[16k+15:16k]` and the effective row on `mem_row`. In every other case all write enables stay low.
- R4: With `in_indexed` high, the effective row is the low 4 bits of the index register chosen by `in_idx_sel`. Otherwise it is `in_row`.
- R5: Opcode 5 writes the accumulator of a source lane into every enabled lane. The source lane is `in_lane_sel`, or the low 3 bits of the selected index register when `in_indexed` is high. The source value is taken before any lane updates, even when the source lane is itself disabled.
- R6: A lane whose mask bit is 0 keeps its accumulator under opcodes 1, 3, 4 and 5 and gets no write enable under opcode 2.
- R7: Opcode 6 compares each lane's signed accumulator with its signed bank word. `in_cmp` selects the test: 0 less, 1 less-or-equal, 2 equal, 3 not equal, 4 greater, 5 greater-or-equal, 6 and 7 never true. Bit k of the result is 1 only for an enabled lane k whose test holds. The next cycle the result appears on `cmp_flags` and in the selected index register.
- R8: Opcode 7 loads the mask from the selected index register. Opcode 8 inverts the mask. Opcode 9 sets the mask to all ones. Opcode 10 writes `in_imm` into the selected index register. Opcode 11 copies the mask into the selected index register. None of these depends on the mask.
- R9: While `in_valid` is low, no accumulator, mask, flag or index register changes and no write enable rises, whatever the opcode.
- R10: Opcodes 0, 12, 13, 14 and 15 change no state and raise no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode strobe for this cycle |
| in_op | input | 4 | Opcode |
| in_indexed | input | 1 | Take row or source lane from an index register |
| in_row | input | 4 | Immediate row address |
| in_idx_sel | input | 2 | Index register select |
| in_lane_sel | input | 3 | Immediate broadcast source lane |
| in_cmp | input | 3 | Compare test select |
| in_imm | input | 8 | Constant for an index register write |
| mem_rd_data | input | 128 | Per-lane bank words at `mem_row`, lane k in bits 16k+15:16k |
| mem_row | output | 4 | Effective row address |
| mem_wr_en | output | 8 | Per-lane bank write enable |
| mem_wr_data | output | 128 | Per-lane write word, lane k in bits 16k+15:16k |
| lane_mask | output | 8 | Current lane enable mask |
| cmp_flags | output | 8 | Result of the latest compare |

## Verification
Masking and broadcast meet in one cycle when the source lane of a broadcast is disabled. The mask is loaded with the source lane cleared, a load then changes every other lane, and the broadcast follows. A store afterwards must show the source lane's old value in all the enabled lanes. The source lane itself must not have taken the loaded word. A compare under a partial mask is judged the same way: the disabled lanes must read zero in the flags even where their test would hold.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_LOAD     = 4'd1,
        OP_STORE    = 4'd2,
        OP_ADD      = 4'd3,
        OP_MUL      = 4'd4,
        OP_BCAST    = 4'd5,
        OP_CMP      = 4'd6,
        OP_MSK_LD   = 4'd7,
        OP_MSK_INV  = 4'd8,
        OP_MSK_ALL  = 4'd9,
        OP_IDX_SET  = 4'd10,
        OP_IDX_GETM = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        CMP_LT = 3'd0,
        CMP_LE = 3'd1,
        CMP_EQ = 3'd2,
        CMP_NE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_e;

    // Source of a new accumulator value
    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_ADD = 2'd1,
        SRC_MUL = 2'd2,
        SRC_BC  = 2'd3
    } src_e;

    typedef struct packed {
        logic acc_we;
        src_e src;
        logic store;
        logic cmp;
        logic msk_ld;
        logic msk_inv;
        logic msk_all;
        logic idx_set;
        logic idx_getm;
    } ctrl_t;

    function automatic ctrl_t decode_op(input logic [3:0] raw);
        ctrl_t c;
        c = '0;
        case (op_e'(raw))
            OP_LOAD:     begin c.acc_we = 1'b1; c.src = SRC_MEM; end
            OP_ADD:      begin c.acc_we = 1'b1; c.src = SRC_ADD; end
            OP_MUL:      begin c.acc_we = 1'b1; c.src = SRC_MUL; end
            OP_BCAST:    begin c.acc_we = 1'b1; c.src = SRC_BC;  end
            OP_STORE:    c.store    = 1'b1;
            OP_CMP:      c.cmp      = 1'b1;
            OP_MSK_LD:   c.msk_ld   = 1'b1;
            OP_MSK_INV:  c.msk_inv  = 1'b1;
            OP_MSK_ALL:  c.msk_all  = 1'b1;
            OP_IDX_SET:  c.idx_set  = 1'b1;
            OP_IDX_GETM: c.idx_getm = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_we,
    input  simd_pkg::src_e      src,
    input  logic                lane_en,
    input  logic [2:0]          cmp_kind,
    input  logic [DW-1:0]       rd_data,
    input  logic [DW-1:0]       bc_data,
    output logic [DW-1:0]       acc,
    output logic                cmp_hit
);
    import simd_pkg::*;

    logic [DW-1:0] sum_w;
    logic [DW-1:0] prod_w;
    logic [DW-1:0] nxt;
    logic signed [DW-1:0] lhs;
    logic signed [DW-1:0] rhs;
    logic test;

    assign sum_w  = acc + rd_data;
    assign prod_w = acc * rd_data;   // low DW bits of the product
    assign lhs    = acc;
    assign rhs    = rd_data;

    always_comb begin
        case (src)
            SRC_MEM: nxt = rd_data;
            SRC_ADD: nxt = sum_w;
            SRC_MUL: nxt = prod_w;
            default: nxt = bc_data;
        endcase
    end

    always_comb begin
        case (cmp_e'(cmp_kind))
            CMP_LT:  test = (lhs <  rhs);
            CMP_LE:  test = (lhs <= rhs);
            CMP_EQ:  test = (lhs == rhs);
            CMP_NE:  test = (lhs != rhs);
            CMP_GT:  test = (lhs >  rhs);
            CMP_GE:  test = (lhs >= rhs);
            default: test = 1'b0;
        endcase
        cmp_hit = lane_en & test;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (acc_we && lane_en) begin
            acc <= nxt;
        end
    end

endmodule

// File: rtl/simd_bcast.sv
module simd_bcast #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] acc_flat,
    input  logic [LW-1:0]       src_lane,
    output logic [DW-1:0]       src_val
);
    // Reads the registered accumulators, so the value is the pre-update one
    always_comb begin
        src_val = '0;
        for (int k = 0; k < LANES; k++) begin
            if (LW'(k) == src_lane) begin
                src_val = acc_flat[k*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl #(
    parameter int LANES = 8,
    parameter int NIDX  = 4,
    parameter int IXW   = $clog2(NIDX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msk_ld,
    input  logic             msk_inv,
    input  logic             msk_all,
    input  logic             idx_set,
    input  logic             idx_getm,
    input  logic             cmp_wr,
    input  logic [IXW-1:0]   idx_sel,
    input  logic [LANES-1:0] imm,
    input  logic [LANES-1:0] cmp_bits,
    output logic [LANES-1:0] mask,
    output logic [LANES-1:0] flags,
    output logic [LANES-1:0] idx_val
);
    // Index registers are as wide as the lane count so a compare word fits
    logic [LANES-1:0] idx_q [NIDX];

    assign idx_val = idx_q[idx_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            flags <= '0;
        end else begin
            if (msk_all) begin
                mask <= '1;
            end else if (msk_inv) begin
                mask <= ~mask;
            end else if (msk_ld) begin
                mask <= idx_val;
            end
            if (cmp_wr) begin
                flags <= cmp_bits;
            end
        end
    end

    for (genvar i = 0; i < NIDX; i++) begin : g_idx
        always_ff @(posedge clk) begin
            if (rst) begin
                idx_q[i] <= '0;
            end else if (idx_sel == IXW'(i)) begin
                if (idx_set) begin
                    idx_q[i] <= imm;
                end else if (idx_getm) begin
                    idx_q[i] <= mask;
                end else if (cmp_wr) begin
                    idx_q[i] <= cmp_bits;
                end
            end
        end
    end

endmodule

// File: rtl/simd_array.sv
module simd_array #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int ROWS  = 16,
    parameter int NIDX  = 4,
    parameter int AW    = $clog2(ROWS),
    parameter int LW    = $clog2(LANES),
    parameter int IXW   = $clog2(NIDX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [3:0]          in_op,
    input  logic                in_indexed,
    input  logic [AW-1:0]       in_row,
    input  logic [IXW-1:0]      in_idx_sel,
    input  logic [LW-1:0]       in_lane_sel,
    input  logic [2:0]          in_cmp,
    input  logic [LANES-1:0]    in_imm,
    input  logic [LANES*DW-1:0] mem_rd_data,
    output logic [AW-1:0]       mem_row,
    output logic [LANES-1:0]    mem_wr_en,
    output logic [LANES*DW-1:0] mem_wr_data,
    output logic [LANES-1:0]    lane_mask,
    output logic [LANES-1:0]    cmp_flags
);
    import simd_pkg::*;

    ctrl_t            ctrl;
    logic [LANES-1:0] idx_val;
    logic [LANES-1:0] cmp_bits;
    logic [LW-1:0]    src_lane;
    logic [DW-1:0]    bc_val;
    logic [LANES*DW-1:0] acc_flat;

    always_comb begin
        ctrl = in_valid ? decode_op(in_op) : ctrl_t'('0);
    end

    assign mem_row  = in_indexed ? idx_val[AW-1:0] : in_row;
    assign src_lane = in_indexed ? idx_val[LW-1:0] : in_lane_sel;

    assign mem_wr_en   = {LANES{ctrl.store}} & lane_mask;
    assign mem_wr_data = acc_flat;

    simd_ctrl #(
        .LANES (LANES),
        .NIDX  (NIDX),
        .IXW   (IXW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .msk_ld   (ctrl.msk_ld),
        .msk_inv  (ctrl.msk_inv),
        .msk_all  (ctrl.msk_all),
        .idx_set  (ctrl.idx_set),
        .idx_getm (ctrl.idx_getm),
        .cmp_wr   (ctrl.cmp),
        .idx_sel  (in_idx_sel),
        .imm      (in_imm),
        .cmp_bits (cmp_bits),
        .mask     (lane_mask),
        .flags    (cmp_flags),
        .idx_val  (idx_val)
    );

    simd_bcast #(
        .LANES (LANES),
        .DW    (DW),
        .LW    (LW)
    ) u_bcast (
        .acc_flat (acc_flat),
        .src_lane (src_lane),
        .src_val  (bc_val)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane #(
            .DW (DW)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .acc_we   (ctrl.acc_we),
            .src      (ctrl.src),
            .lane_en  (lane_mask[g]),
            .cmp_kind (in_cmp),
            .rd_data  (mem_rd_data[g*DW +: DW]),
            .bc_data  (bc_val),
            .acc      (acc_flat[g*DW +: DW]),
            .cmp_hit  (cmp_bits[g])
        );
    end

endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [LANES-1:0] mem_wr_en,
    input logic [LANES-1:0] lane_mask,
    input logic [LANES-1:0] cmp_flags
);
    import simd_pkg::*;

    a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> mem_wr_en == '0);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(lane_mask) && $stable(cmp_flags));

    a_r6_masked_no_write: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en & ~lane_mask) == '0);

    a_r3_write_only_on_store: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en != '0 |-> in_valid && in_op == OP_STORE);

    a_r8_mask_all: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == OP_MSK_ALL |=> lane_mask == '1);

    a_r8_mask_inv: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == OP_MSK_INV |=> lane_mask == ~$past(lane_mask));

    a_r7_cmp_masked_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == OP_CMP |=> (cmp_flags & ~$past(lane_mask)) == '0);

endmodule

bind simd_array simd_array_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .mem_wr_en (mem_wr_en),
    .lane_mask (lane_mask),
    .cmp_flags (cmp_flags)
);

// File: tb/simd_array_bench.sv
`timescale 1ns/1ps
module simd_array_bench;

    localparam logic [3:0] NOP = 4'd0, LD = 4'd1, ST = 4'd2, AD = 4'd3, MU = 4'd4,
                           BC = 4'd5, CM = 4'd6, MLD = 4'd7, MINV = 4'd8,
                           MALL = 4'd9, ISET = 4'd10, IGETM = 4'd11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic         in_indexed = 1'b0;
    logic [3:0]   in_row = '0;
    logic [1:0]   in_idx_sel = '0;
    logic [2:0]   in_lane_sel = '0;
    logic [2:0]   in_cmp = '0;
    logic [7:0]   in_imm = '0;
    logic [127:0] mem_rd_data;
    logic [3:0]   mem_row;
    logic [7:0]   mem_wr_en;
    logic [127:0] mem_wr_data;
    logic [7:0]   lane_mask;
    logic [7:0]   cmp_flags;

    // External banks, updated only by the reference model
    logic [15:0] bank [8][16];
    // Reference state
    logic [15:0] m_acc [8];
    logic [7:0]  m_idx [4];
    logic [7:0]  m_mask;
    logic [7:0]  m_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) mem_rd_data[k*16 +: 16] = bank[k][mem_row];
    end

    simd_array u_simd_array (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_indexed(in_indexed), .in_row(in_row), .in_idx_sel(in_idx_sel),
        .in_lane_sel(in_lane_sel), .in_cmp(in_cmp), .in_imm(in_imm),
        .mem_rd_data(mem_rd_data), .mem_row(mem_row), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .lane_mask(lane_mask), .cmp_flags(cmp_flags)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic ix,
                        input logic [3:0] row, input logic [1:0] isel,
                        input logic [2:0] lsel, input logic [2:0] ck,
                        input logic [7:0] imm, input string tag);
        logic [3:0]  erow;
        logic [2:0]  src;
        logic [7:0]  exp_we;
        logic [15:0] bval;
        logic [7:0]  res;
        @(negedge clk);
        chk(lane_mask == m_mask, tag, "lane_mask", lane_mask, m_mask);
        chk(cmp_flags == m_flags, tag, "cmp_flags", cmp_flags, m_flags);
        in_valid = v; in_op = op; in_indexed = ix; in_row = row;
        in_idx_sel = isel; in_lane_sel = lsel; in_cmp = ck; in_imm = imm;
        #1;
        erow = ix ? m_idx[isel][3:0] : row;
        src  = ix ? m_idx[isel][2:0] : lsel;
        if (v && (op == LD || op == ST || op == AD || op == MU || op == CM))
            chk(mem_row == erow, tag, "mem_row", mem_row, erow);
        exp_we = (v && op == ST) ? m_mask : 8'h00;
        chk(mem_wr_en == exp_we, tag, "mem_wr_en", mem_wr_en, exp_we);
        for (int k = 0; k < 8; k++) begin
            if (exp_we[k])
                chk(mem_wr_data[k*16 +: 16] == m_acc[k], tag, "mem_wr_data",
                    mem_wr_data[k*16 +: 16], m_acc[k]);
        end
        @(posedge clk);
        #1;
        if (v) begin
            bval = m_acc[src];
            res = '0;
            for (int k = 0; k < 8; k++) begin
                int a;
                int b;
                bit t;
                a = int'($signed(m_acc[k]));
                b = int'($signed(bank[k][erow]));
                case (ck)
                    3'd0: t = a < b;
                    3'd1: t = a <= b;
                    3'd2: t = a == b;
                    3'd3: t = a != b;
                    3'd4: t = a > b;
                    3'd5: t = a >= b;
                    default: t = 1'b0;
                endcase
                res[k] = t & m_mask[k];
            end
            case (op)
                LD: for (int k = 0; k < 8; k++) if (m_mask[k]) m_acc[k] = bank[k][erow];
                AD: for (int k = 0; k < 8; k++) if (m_mask[k]) m_acc[k] = m_acc[k] + bank[k][erow];
                MU: for (int k = 0; k < 8; k++) if (m_mask[k]) m_acc[k] = m_acc[k] * bank[k][erow];
                BC: for (int k = 0; k < 8; k++) if (m_mask[k]) m_acc[k] = bval;
                ST: for (int k = 0; k < 8; k++) if (m_mask[k]) bank[k][erow] = m_acc[k];
                CM: begin m_flags = res; m_idx[isel] = res; end
                MLD:   m_mask = m_idx[isel];
                MINV:  m_mask = ~m_mask;
                MALL:  m_mask = 8'hFF;
                ISET:  m_idx[isel] = imm;
                IGETM: m_idx[isel] = m_mask;
                default: ;
            endcase
        end
    endtask

    task automatic go(input logic [3:0] op, input logic [3:0] row, input string tag);
        step(1'b1, op, 1'b0, row, 2'd0, 3'd0, 3'd0, 8'h00, tag);
    endtask
    task automatic goix(input logic [3:0] op, input logic [1:0] isel, input string tag);
        step(1'b1, op, 1'b1, 4'd0, isel, 3'd0, 3'd0, 8'h00, tag);
    endtask
    task automatic msk(input logic [3:0] op, input logic [1:0] isel, input string tag);
        step(1'b1, op, 1'b0, 4'd0, isel, 3'd0, 3'd0, 8'h00, tag);
    endtask
    task automatic iset(input logic [1:0] isel, input logic [7:0] imm, input string tag);
        step(1'b1, ISET, 1'b0, 4'd0, isel, 3'd0, 3'd0, imm, tag);
    endtask
    task automatic cmpop(input logic [2:0] ck, input logic [3:0] row, input logic [1:0] isel,
                         input string tag);
        step(1'b1, CM, 1'b0, row, isel, 3'd0, ck, 8'h00, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_acc[k] = '0;
            for (int r = 0; r < 16; r++) bank[k][r] = 16'(k * 1237 + r * 4099 + 40000);
            // Row 9: equal to row 1 on even lanes, row 1 plus 5 on odd lanes
            bank[k][9] = (k % 2 == 0) ? bank[k][1] : bank[k][1] + 16'd5;
        end
        for (int i = 0; i < 4; i++) m_idx[i] = '0;
        m_mask = 8'hFF;
        m_flags = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, store of zero accumulators
        go(ST, 4'd0, "R1");
        // R2: load, add, multiply; R3: store of results
        go(LD, 4'd1, "R2");
        go(AD, 4'd2, "R2");
        go(MU, 4'd3, "R2");
        go(ST, 4'd4, "R3");
        // R4: indexed row addressing
        iset(2'd1, 8'h25, "R8");
        goix(LD, 2'd1, "R4");
        goix(ST, 2'd1, "R4");
        // R5: broadcast immediate and indexed lane
        step(1'b1, BC, 1'b0, 4'd0, 2'd0, 3'd3, 3'd0, 8'h00, "R5");
        go(ST, 4'd6, "R5");
        go(LD, 4'd2, "R5");
        iset(2'd3, 8'hFE, "R5");
        step(1'b1, BC, 1'b1, 4'd0, 2'd3, 3'd0, 3'd0, 8'h00, "R5");
        go(ST, 4'd7, "R5");
        // R7: all six tests and the two never-true codes
        go(LD, 4'd1, "R7");
        for (int c = 0; c < 8; c++) cmpop(3'(c), 4'd9, 2'd0, "R7");
        // R6: masked if/else using the equal-test result
        cmpop(3'd2, 4'd9, 2'd0, "R7");
        msk(MLD, 2'd0, "R8");
        go(AD, 4'd2, "R6");
        go(ST, 4'd10, "R6");
        msk(MINV, 2'd0, "R8");
        go(MU, 4'd3, "R6");
        go(ST, 4'd11, "R6");
        msk(MALL, 2'd0, "R8");
        go(ST, 4'd12, "R6");
        // R5 with R6: broadcast from a disabled source lane
        iset(2'd2, 8'hF7, "R8");
        msk(MLD, 2'd2, "R8");
        go(LD, 4'd4, "R6");
        step(1'b1, BC, 1'b0, 4'd0, 2'd0, 3'd3, 3'd0, 8'h00, "R5");
        msk(MALL, 2'd0, "R8");
        go(ST, 4'd13, "R5");
        // R7: compare under a partial mask
        msk(MLD, 2'd2, "R8");
        cmpop(3'd5, 4'd9, 2'd1, "R7");
        // R8: mask copied out and back
        msk(IGETM, 2'd3, "R8");
        msk(MALL, 2'd0, "R8");
        msk(MLD, 2'd3, "R8");
        msk(MALL, 2'd0, "R8");
        // R9: strobe low with active opcodes
        step(1'b0, LD, 1'b0, 4'd1, 2'd0, 3'd0, 3'd0, 8'h00, "R9");
        step(1'b0, ST, 1'b0, 4'd1, 2'd0, 3'd0, 3'd0, 8'h00, "R9");
        step(1'b0, MINV, 1'b0, 4'd0, 2'd0, 3'd0, 3'd0, 8'h00, "R9");
        step(1'b0, CM, 1'b0, 4'd9, 2'd0, 3'd0, 3'd3, 8'h00, "R9");
        go(ST, 4'd14, "R9");
        // R10: unused opcodes
        go(4'd15, 4'd1, "R10");
        go(4'd12, 4'd2, "R10");
        go(NOP, 4'd3, "R10");
        go(ST, 4'd15, "R10");
        step(1'b0, NOP, 1'b0, 4'd0, 2'd0, 3'd0, 3'd0, 8'h00, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule